// File: doc/BRIEF.md
# Guarded Pad Configuration Register Bank

This block holds the per-pin pad and function-routing settings for one eight-pin general-purpose port. A simple register bus writes and reads them. The settings are drive strength, open-drain, pull resistors, slew, digital enable, analog select and alternate-function routing. Each setting is a byte with one bit per pin, and every stored byte is driven straight out to the pad ring.

The alternate-function routing is protected against stray writes. A commit mask decides which routing bits a write may change. The commit mask itself can only be rewritten after a fixed 32-bit key has been written to the lock register. The top of the map returns a set of read-only identification bytes, one per word.

A build parameter selects between two variants. The extended variant has the pad settings, the lock and the commit mask. The base variant keeps only the routing register and the identification bytes. In the base variant, accesses to the pad-setting window are bad offsets. A sticky error flag records any access to an offset the variant does not decode.

Top module: `padcfg_bank`

## Requirements
- R1: After reset, the bank is in this state: locked, commit mask 0xFF, 2 mA drive byte 0xFF, every other setting 0, and the error flag 0.
- R2: A write of exactly 0x0ACCE551 to the lock word (byte offset 0x520) unlocks the bank. A write of any other value locks it. A read of the lock word returns 1 while locked and 0 while unlocked, with all upper bits 0.
- R3: While unlocked, a write to the commit word (0x524) stores the low byte of the write data. While locked, the write leaves the commit mask unchanged.
- R4: A write to the routing word (0x420) changes only those routing bits whose commit bit is 1. Each remaining bit keeps its old value.
- R5: In the extended variant, each pad setting stores the low byte of a write and returns it zero-extended on a read. The offsets are:
  - 2 mA drive at 0x500
  - 4 mA drive at 0x504
  - 8 mA drive at 0x508
  - open-drain at 0x50C
  - pull-up at 0x510
  - pull-down at 0x514
  - slew at 0x518
  - digital enable at 0x51C
  - analog select at 0x528
- R6: A read of byte offsets 0xFD0 to 0xFFF returns identification byte number (offset − 0xFD0)/4 in bits 7:0, with bits 31:8 zero. Byte n is bits 8n+7:8n of the variant's ID parameter.
- R7: In the base variant, the following accesses are bad offsets: the pad settings, the lock word and the commit word. Reads of them return 0, writes to them are dropped, and the pad-setting outputs stay 0.
- R8: Any read or write to an offset that the variant does not decode sets the error flag on the clock edge of the access. The flag then stays set until reset.
- R9: In the base variant the commit mask is fixed at all ones, so a write to the routing word replaces the whole byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| alt_func_sel | output | PIN_W | Alternate-function routing per pin |
| drive_2ma | output | PIN_W | 2 mA drive select |
| drive_4ma | output | PIN_W | 4 mA drive select |
| drive_8ma | output | PIN_W | 8 mA drive select |
| open_drain | output | PIN_W | Open-drain enable |
| pull_up | output | PIN_W | Pull-up enable |
| pull_down | output | PIN_W | Pull-down enable |
| slew_ctl | output | PIN_W | Slew-rate control |
| digital_en | output | PIN_W | Digital function enable |
| analog_sel | output | PIN_W | Analog mode select |
| access_err | output | 1 | Sticky bad-offset flag |

## Verification
The bench sweeps all 256 commit masks against several routing patterns. A design that gated the wrong polarity, or ignored the mask, would show routing bits changing outside the mask. It writes keys that differ from the unlock value in a single bit. A design comparing only part of the key would unlock on them, and one that ignored the lock would accept commit writes while locked. A base-variant instance receives the same traffic as the extended one, which exposes any variant that still stores pad settings, returns non-zero for them, or fails to flag them. The error flag is checked on reads as well as writes, after later good accesses and across a reset, which exposes a flag that is cleared by valid traffic or set by mapped offsets.

// File: rtl/padcfg_pkg.sv
// Shared constants for the pad configuration bank: word addresses of the
// decoded registers, the unlock key and the decode target encoding.
// Assumes a 4 KiB window addressed by byte offset, word-granular decode.
package padcfg_pkg;
    localparam int          EXT_COUNT  = 9;
    localparam int          ID_COUNT   = 12;
    localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;

    // Word addresses (byte offset >> 2); the pad window order is fixed by the map.
    localparam logic [9:0]  WA_ALTF    = 10'h108;
    localparam logic [9:0]  WA_EXT_LO  = 10'h140;
    localparam logic [9:0]  WA_EXT_HI  = 10'h147;
    localparam logic [9:0]  WA_LOCK    = 10'h148;
    localparam logic [9:0]  WA_COMMIT  = 10'h149;
    localparam logic [9:0]  WA_ANALOG  = 10'h14A;
    localparam logic [9:0]  WA_ID_LO   = 10'h3F4;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ALTF,
        TGT_EXT,
        TGT_LOCK,
        TGT_COMMIT,
        TGT_ID
    } tgt_e;
endpackage

// File: rtl/padcfg_decode.sv
// Address decoder for the pad configuration bank.
// Maps a byte offset to a register target plus an index into the pad
// setting array or the ID byte list. When EXTENDED is 0 the pad window,
// lock and commit words decode as TGT_NONE (bad offset).
module padcfg_decode
    import padcfg_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic [11:0] addr,
    output tgt_e        target,
    output logic [3:0]  ext_idx,
    output logic [3:0]  id_idx
);
    logic [9:0] wa;
    assign wa = addr[11:2];

    // Purpose: classify the word address into one target and its index.
    always_comb begin
        target  = TGT_NONE;
        ext_idx = '0;
        id_idx  = '0;
        if (wa == WA_ALTF) begin
            target = TGT_ALTF;
        end else if (wa >= WA_ID_LO) begin
            target = TGT_ID;
            id_idx = 4'(wa - WA_ID_LO);
        end else if (EXTENDED) begin
            if (wa >= WA_EXT_LO && wa <= WA_EXT_HI) begin
                target  = TGT_EXT;
                ext_idx = 4'(wa - WA_EXT_LO);
            end else if (wa == WA_ANALOG) begin
                target  = TGT_EXT;
                ext_idx = 4'(EXT_COUNT - 1);
            end else if (wa == WA_LOCK) begin
                target = TGT_LOCK;
            end else if (wa == WA_COMMIT) begin
                target = TGT_COMMIT;
            end
        end
    end
endmodule

// File: rtl/padcfg_lock.sv
// Key lock and commit mask for the pad configuration bank.
// The lock opens only on the exact key. The commit mask accepts writes only
// while open. With ENABLE = 0 the bank is permanently locked and the
// commit mask is fixed at all ones.
module padcfg_lock #(
    parameter int          W      = 8,
    parameter bit          ENABLE = 1'b1,
    parameter logic [31:0] KEY    = 32'h0ACC_E551
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_we,
    input  logic          commit_we,
    input  logic [31:0]   wdata,
    output logic          locked,
    output logic [W-1:0]  commit
);
    generate
        if (ENABLE) begin : g_lock
            logic         locked_q;
            logic [W-1:0] commit_q;

            // Purpose: lock state follows every lock-word write.
            always_ff @(posedge clk) begin
                if (!rst_n)       locked_q <= 1'b1;
                else if (lock_we) locked_q <= (wdata != KEY);
            end

            // Purpose: commit mask takes the low byte only while unlocked.
            always_ff @(posedge clk) begin
                if (!rst_n)                      commit_q <= '1;
                else if (commit_we && !locked_q) commit_q <= wdata[W-1:0];
            end

            assign locked = locked_q;
            assign commit = commit_q;
        end else begin : g_nolock
            logic unused_nolock;
            assign unused_nolock = ^{clk, rst_n, lock_we, commit_we, wdata};
            assign locked = 1'b1;
            assign commit = '1;
        end
    endgenerate
endmodule

// File: rtl/padcfg_cfg_reg.sv
// One per-pin configuration byte with a bitwise write mask.
// Bits with a 0 in wmask keep their value on a write.
module padcfg_cfg_reg #(
    parameter int           W   = 8,
    parameter logic [W-1:0] RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [W-1:0]  wmask,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  q
);
    // Purpose: masked merge of write data into the stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST;
        else if (we) q <= (q & ~wmask) | (wdata & wmask);
    end
endmodule

// File: rtl/padcfg_bank.sv
// Guarded pad configuration register bank for one GPIO port.
// Holds the routing byte (guarded by the commit mask), the pad settings,
// the key lock and the ID bytes. A sticky flag records bad offsets.
// Assumes one access per cycle on bus_sel. bus_rdata is combinational
// from bus_addr, and writes take effect on the clock edge.
module padcfg_bank
    import padcfg_pkg::*;
#(
    parameter int                        PIN_W    = 8,
    parameter bit                        EXTENDED = 1'b1,
    parameter logic [8*ID_COUNT-1:0]     ID_BASE  = 96'hB1_05_F0_0D_00_21_37_55_00_00_00_00,
    parameter logic [8*ID_COUNT-1:0]     ID_EXT   = 96'hB1_05_F0_0D_01_2C_37_55_00_00_00_00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [PIN_W-1:0]  alt_func_sel,
    output logic [PIN_W-1:0]  drive_2ma,
    output logic [PIN_W-1:0]  drive_4ma,
    output logic [PIN_W-1:0]  drive_8ma,
    output logic [PIN_W-1:0]  open_drain,
    output logic [PIN_W-1:0]  pull_up,
    output logic [PIN_W-1:0]  pull_down,
    output logic [PIN_W-1:0]  slew_ctl,
    output logic [PIN_W-1:0]  digital_en,
    output logic [PIN_W-1:0]  analog_sel,
    output logic              access_err
);
    localparam logic [8*ID_COUNT-1:0] ID_SEL   = EXTENDED ? ID_EXT : ID_BASE;
    localparam logic [PIN_W-1:0]      ALL_ONES = '1;
    localparam logic [PIN_W-1:0]      ZEROS    = '0;

    tgt_e             target;
    logic [3:0]       ext_idx;
    logic [3:0]       id_idx;
    logic             wr_cyc;
    logic             locked;
    logic [PIN_W-1:0] commit;
    logic [PIN_W-1:0] ext_q [EXT_COUNT];

    assign wr_cyc = bus_sel && bus_wr;

    padcfg_decode #(.EXTENDED(EXTENDED)) u_decode (
        .addr    (bus_addr),
        .target  (target),
        .ext_idx (ext_idx),
        .id_idx  (id_idx)
    );

    padcfg_lock #(.W(PIN_W), .ENABLE(EXTENDED), .KEY(UNLOCK_KEY)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_we   (wr_cyc && target == TGT_LOCK),
        .commit_we (wr_cyc && target == TGT_COMMIT),
        .wdata     (bus_wdata),
        .locked    (locked),
        .commit    (commit)
    );

    padcfg_cfg_reg #(.W(PIN_W), .RST(ZEROS)) u_altf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_cyc && target == TGT_ALTF),
        .wmask (commit),
        .wdata (bus_wdata[PIN_W-1:0]),
        .q     (alt_func_sel)
    );

    generate
        if (EXTENDED) begin : g_ext
            for (genvar i = 0; i < EXT_COUNT; i++) begin : g_reg
                padcfg_cfg_reg #(.W(PIN_W), .RST((i == 0) ? ALL_ONES : ZEROS)) u_reg (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .we    (wr_cyc && target == TGT_EXT && ext_idx == 4'(i)),
                    .wmask (ALL_ONES),
                    .wdata (bus_wdata[PIN_W-1:0]),
                    .q     (ext_q[i])
                );
            end
        end else begin : g_noext
            for (genvar i = 0; i < EXT_COUNT; i++) begin : g_zero
                assign ext_q[i] = ZEROS;
            end
        end
    endgenerate

    assign drive_2ma  = ext_q[0];
    assign drive_4ma  = ext_q[1];
    assign drive_8ma  = ext_q[2];
    assign open_drain = ext_q[3];
    assign pull_up    = ext_q[4];
    assign pull_down  = ext_q[5];
    assign slew_ctl   = ext_q[6];
    assign digital_en = ext_q[7];
    assign analog_sel = ext_q[8];

    // Purpose: read mux, zero-extending every byte to the bus width.
    always_comb begin
        bus_rdata = '0;
        case (target)
            TGT_ALTF:   bus_rdata[PIN_W-1:0] = alt_func_sel;
            TGT_EXT: begin
                for (int i = 0; i < EXT_COUNT; i++) begin
                    if (ext_idx == 4'(i)) bus_rdata[PIN_W-1:0] = ext_q[i];
                end
            end
            TGT_LOCK:   bus_rdata[0] = locked;
            TGT_COMMIT: bus_rdata[PIN_W-1:0] = commit;
            TGT_ID: begin
                for (int i = 0; i < ID_COUNT; i++) begin
                    if (id_idx == 4'(i)) bus_rdata[7:0] = ID_SEL[8*i +: 8];
                end
            end
            default:    bus_rdata = '0;
        endcase
    end

    // Purpose: sticky record of any access to an undecoded offset.
    always_ff @(posedge clk) begin
        if (!rst_n)                             access_err <= 1'b0;
        else if (bus_sel && target == TGT_NONE) access_err <= 1'b1;
    end
endmodule

// File: rtl/padcfg_bank_chk.sv
// Property checker for padcfg_bank, attached by bind. Observes the bus,
// the lock state, the commit mask and the outputs.
module padcfg_bank_chk
    import padcfg_pkg::*;
#(
    parameter int PIN_W    = 8,
    parameter bit EXTENDED = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [9:0]        wa,
    input logic [31:0]       bus_wdata,
    input logic              locked,
    input logic [PIN_W-1:0]  commit,
    input logic [PIN_W-1:0]  alt_func_sel,
    input logic [PIN_W-1:0]  drive_2ma,
    input logic              access_err
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (locked && commit == '1 && !access_err && alt_func_sel == '0
                          && (!EXTENDED || drive_2ma == '1)));

    // R2
    key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (EXTENDED && bus_sel && bus_wr && wa == WA_LOCK && bus_wdata == UNLOCK_KEY) |=> !locked);

    // R2
    key_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && wa == WA_LOCK && bus_wdata != UNLOCK_KEY) |=> locked);

    // R3
    commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(commit));

    // R4
    altf_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((alt_func_sel ^ $past(alt_func_sel)) & ~$past(commit)) == '0));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |=> access_err);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_err) |-> $past(bus_sel));
endmodule

bind padcfg_bank padcfg_bank_chk #(.PIN_W(PIN_W), .EXTENDED(EXTENDED)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .wa           (bus_addr[11:2]),
    .bus_wdata    (bus_wdata),
    .locked       (locked),
    .commit       (commit),
    .alt_func_sel (alt_func_sel),
    .drive_2ma    (drive_2ma),
    .access_err   (access_err)
);

// File: tb/padcfg_bank_test.sv
// Self-checking bench: an extended and a base instance share one bus.
module padcfg_bank_test;
    localparam logic [95:0] IDB = 96'hB1_05_F0_0D_00_21_37_55_00_00_00_00;
    localparam logic [95:0] IDE = 96'hB1_05_F0_0D_01_2C_37_55_00_00_00_00;
    localparam logic [31:0] KEY = 32'h0ACC_E551;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_e, rd_b;
    logic [7:0] alt_e, alt_b, ep [9], bp [9];
    logic err_e, err_b;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    padcfg_bank #(.PIN_W(8), .EXTENDED(1'b1), .ID_BASE(IDB), .ID_EXT(IDE)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_e), .alt_func_sel(alt_e),
        .drive_2ma(ep[0]), .drive_4ma(ep[1]), .drive_8ma(ep[2]), .open_drain(ep[3]),
        .pull_up(ep[4]), .pull_down(ep[5]), .slew_ctl(ep[6]), .digital_en(ep[7]),
        .analog_sel(ep[8]), .access_err(err_e));

    padcfg_bank #(.PIN_W(8), .EXTENDED(1'b0), .ID_BASE(IDB), .ID_EXT(IDE)) uut_base (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_b), .alt_func_sel(alt_b),
        .drive_2ma(bp[0]), .drive_4ma(bp[1]), .drive_8ma(bp[2]), .open_drain(bp[3]),
        .pull_up(bp[4]), .pull_down(bp[5]), .slew_ctl(bp[6]), .digital_en(bp[7]),
        .analog_sel(bp[8]), .access_err(err_b));

    function automatic logic [11:0] ext_off(input int i);
        return (i == 8) ? 12'h528 : 12'(12'h500 + 4 * i);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge after the write edge.
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] ve, output logic [31:0] vb);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 ve = rd_e; vb = rd_b;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] ve, vb;
        logic [7:0]  exp_ext [9];
        logic [7:0]  exp_alt, exp_altb, cm;
        do_reset();

        // R1 reset state at the ports of both instances
        check("R1 alt", {24'h0, alt_e}, 32'h0);
        check("R1 drv2", {24'h0, ep[0]}, 32'hFF);
        for (int i = 1; i < 9; i++) check("R1 ext zero", {24'h0, ep[i]}, 32'h0);
        check("R1 err", {31'h0, err_e}, 32'h0);
        check("R1 base err", {31'h0, err_b}, 32'h0);
        bus_read(12'hFD0, ve, vb);
        check("R8 mapped read no err", {31'h0, err_b}, 32'h0);
        bus_read(12'h520, ve, vb);
        check("R1 lock read", ve, 32'h1);
        check("R7 base lock read", vb, 32'h0);
        bus_read(12'h524, ve, vb);
        check("R1 commit read", ve, 32'hFF);
        check("R7 base commit read", vb, 32'h0);
        check("R7 base err set", {31'h0, err_b}, 32'h1);
        check("R8 ext err clear", {31'h0, err_e}, 32'h0);

        // R6 ID sweep
        for (int n = 0; n < 12; n++) begin
            bus_read(12'(12'hFD0 + 4 * n), ve, vb);
            check("R6 ext id", ve, {24'h0, IDE[8*n +: 8]});
            check("R6 base id", vb, {24'h0, IDB[8*n +: 8]});
        end

        // R5 / R7 pad-setting sweep
        for (int i = 0; i < 9; i++) exp_ext[i] = (i == 0) ? 8'hFF : 8'h00;
        for (int i = 0; i < 9; i++) begin
            for (int k = 0; k < 5; k++) begin
                logic [7:0] v;
                case (k)
                    0: v = 8'h00; 1: v = 8'hFF; 2: v = 8'hA5; 3: v = 8'h5A;
                    default: v = 8'(29 * i + 7);
                endcase
                bus_write(ext_off(i), 32'hDEAD_BE00 | {24'h0, v});
                exp_ext[i] = v;
                for (int j = 0; j < 9; j++)
                    check("R5 ext port", {24'h0, ep[j]}, {24'h0, exp_ext[j]});
                bus_read(ext_off(i), ve, vb);
                check("R5 ext readback", ve, {24'h0, v});
                check("R7 base ext read", vb, 32'h0);
                check("R7 base ext port", {24'h0, bp[i]}, 32'h0);
            end
        end
        check("R8 ext err after pad sweep", {31'h0, err_e}, 32'h0);

        // R2 lock key handling
        bus_write(12'h520, KEY);
        bus_read(12'h520, ve, vb);
        check("R2 unlock", ve, 32'h0);
        bus_write(12'h520, KEY ^ 32'h1);
        bus_read(12'h520, ve, vb);
        check("R2 near key locks", ve, 32'h1);
        bus_write(12'h520, KEY);
        bus_write(12'h520, KEY ^ 32'h8000_0000);
        bus_read(12'h520, ve, vb);
        check("R2 top bit key locks", ve, 32'h1);
        bus_write(12'h520, 32'h0);
        bus_read(12'h520, ve, vb);
        check("R2 zero locks", ve, 32'h1);

        // R3 commit guard
        bus_write(12'h524, 32'h3C);
        bus_read(12'h524, ve, vb);
        check("R3 locked commit ignored", ve, 32'hFF);
        bus_write(12'h520, KEY);
        bus_write(12'h524, 32'hFFFF_FF3C);
        bus_read(12'h524, ve, vb);
        check("R3 unlocked commit low byte", ve, 32'h3C);

        // R4 / R9 routing sweep over every commit mask
        exp_alt = 8'h00; exp_altb = 8'h00;
        for (int c = 0; c < 256; c++) begin
            cm = 8'(c);
            bus_write(12'h520, KEY);
            bus_write(12'h524, {24'h0, cm});
            bus_write(12'h520, 32'h0);
            for (int k = 0; k < 3; k++) begin
                logic [7:0] v;
                v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (cm ^ 8'h96);
                bus_write(12'h420, {24'h0, v});
                exp_alt  = (exp_alt & ~cm) | (v & cm);
                exp_altb = v;
                check("R4 alt port", {24'h0, alt_e}, {24'h0, exp_alt});
                check("R9 base alt port", {24'h0, alt_b}, {24'h0, exp_altb});
                if (k == 2) begin
                    bus_read(12'h420, ve, vb);
                    check("R4 alt readback", ve, {24'h0, exp_alt});
                    check("R9 base alt readback", vb, {24'h0, exp_altb});
                end
            end
        end

        // R8 sticky error flag
        check("R8 ext err still clear", {31'h0, err_e}, 32'h0);
        bus_read(12'h52C, ve, vb);
        check("R8 unmapped read data", ve, 32'h0);
        check("R8 unmapped read sets err", {31'h0, err_e}, 32'h1);
        bus_write(12'h420, 32'h0);
        bus_read(12'h500, ve, vb);
        check("R8 err sticky", {31'h0, err_e}, 32'h1);
        do_reset();
        check("R8 reset clears err", {31'h0, err_e}, 32'h0);
        check("R8 reset clears base err", {31'h0, err_b}, 32'h0);
        bus_write(12'h000, 32'hFF);
        check("R8 unmapped write sets err", {31'h0, err_e}, 32'h1);
        check("R1 drv2 after reset", {24'h0, ep[0]}, 32'hFF);
        check("R1 alt after reset", {24'h0, alt_e}, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule